// File: doc/BRIEF.md
# Byte-Lane Synchronous RAM Bridge

This block sits between the data-memory port of a 16-bit processor and a single-port synchronous RAM. It holds the RAM array itself: 4096 words of 16 bits, stored as two independent 8-bit lanes. The processor side uses an active-low select, a 12-bit word address, and separate write-data and read-data buses. A 2-bit active-low write strobe carries one bit per byte lane. The processor's byte address maps to the word address by dropping bit 0, so byte 0x0100 is word 0x080.

The bridge converts the processor-side controls into the RAM-side controls: a clock enable, one global write enable and an active-high byte-enable pair. These three are also driven out as ports so that the surrounding logic can observe them. Reads always return the whole word, one clock edge after the selected cycle. A write finishes at the edge that ends its cycle and changes only the lanes whose strobe is low.

Top module: `sram_bridge`

## Requirements
- R1: The storage holds 4096 independent 16-bit words selected by the 12-bit word address `addr`; both address 0 and address 4095 are usable.
- R2: `ram_ce` is high exactly when `cen_n` is low.
- R3: `ram_we` is high exactly when `wen_n` is not 2'b11, whether or not the block is selected.
- R4: `ram_be` equals the bitwise inverse of `wen_n`. Bit 0 covers the low byte `[7:0]` and bit 1 covers the high byte `[15:8]`.
- R5: In a selected cycle, `wen_n` = 2'b00 stores both bytes, 2'b10 stores only the low byte and 2'b01 stores only the high byte. A lane that is not enabled keeps its previous contents exactly.
- R6: A selected cycle with `wen_n` = 2'b11 is a read. It stores nothing, and after the next rising clock edge `rdata` shows all 16 bits of the addressed word.
- R7: While `cen_n` is high, nothing is stored and `rdata` keeps its last value.
- R8: After a selected write cycle, `rdata` shows the word as it is now stored: new bytes in the enabled lanes and old bytes in the others.
- R9: A read of an address in the cycle straight after a write to that same address returns the newly written data.
- R10: While `rst_n` is low, and right after it is released, `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the read register |
| cen_n | input | 1 | Active-low select from the processor |
| addr | input | 12 | Word address |
| wdata | input | 16 | Write data from the processor |
| wen_n | input | 2 | Active-low write strobe, bit 0 low byte, bit 1 high byte |
| rdata | output | 16 | Registered read data to the processor |
| ram_ce | output | 1 | RAM clock enable |
| ram_we | output | 1 | RAM global write enable |
| ram_be | output | 2 | RAM byte enables, active high |

## Verification
The bench targets the following corner cases:

- **Partial writes.** It checks that the lane left untouched by a partial write survives. A design with swapped or merged lanes would corrupt the other byte or write the wrong half.
- **Deselected cycles.** It drives changing address, data and strobes while deselected, then reads back. A design that ignores the select would write stray data or let `rdata` drift.
- **Write followed by read.** It runs a write followed at once by a read of the same address. A design with read-before-write behaviour would return stale data.
- **Address extremes and mixed traffic.** It covers the two extreme addresses. Random mixed traffic over a small address pool then catches wrong lane decoding and a wrong read latency.

// File: rtl/sram_bridge_pkg.sv
package sram_bridge_pkg;
    parameter int ADDR_W = 12;
    parameter int DATA_W = 16;
    parameter int LANE_W = 8;
    localparam int LANES = DATA_W / LANE_W;

    // RAM-side control bundle produced from the processor strobes
    typedef struct packed {
        logic             ce;
        logic             we;
        logic [LANES-1:0] be;
    } ram_ctl_t;
endpackage

// File: rtl/sram_strobe_decode.sv
module sram_strobe_decode
    import sram_bridge_pkg::*;
(
    input  logic             cen_n,
    input  logic [LANES-1:0] wen_n,
    output ram_ctl_t         ctl
);
    always_comb begin
        ctl    = '0;
        ctl.ce = ~cen_n;
        ctl.be = ~wen_n;
        // any lane strobe low marks a write cycle
        ctl.we = ~(&wen_n);
    end
endmodule

// File: rtl/sram_byte_lane.sv
module sram_byte_lane #(
    parameter int AW = 12,
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [LW-1:0] din,
    output logic [LW-1:0] dout
);
    localparam int DEPTH = 1 << AW;

    typedef struct packed {
        logic [LW-1:0] dout;
    } lane_st_t;

    logic [LW-1:0] mem [DEPTH];
    lane_st_t st_d, st_q;

    // write-through: output shows the value the lane holds after this edge
    always_comb begin
        st_d = st_q;
        if (en) begin
            st_d.dout = wr ? din : mem[addr];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (en && wr) mem[addr] <= din;
    end

    assign dout = st_q.dout;
endmodule

// File: rtl/sram_bridge.sv
module sram_bridge
    import sram_bridge_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W,
    parameter int LW = LANE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cen_n,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [DW/LW-1:0] wen_n,
    output logic [DW-1:0]   rdata,
    output logic            ram_ce,
    output logic            ram_we,
    output logic [DW/LW-1:0] ram_be
);
    localparam int NL = DW / LW;

    ram_ctl_t ctl;

    sram_strobe_decode u_dec (
        .cen_n (cen_n),
        .wen_n (wen_n),
        .ctl   (ctl)
    );

    assign ram_ce = ctl.ce;
    assign ram_we = ctl.we;
    assign ram_be = ctl.be;

    for (genvar g = 0; g < NL; g++) begin : g_lane
        sram_byte_lane #(.AW(AW), .LW(LW)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (ctl.ce),
            .wr    (ctl.we & ctl.be[g]),
            .addr  (addr),
            .din   (wdata[g*LW +: LW]),
            .dout  (rdata[g*LW +: LW])
        );
    end
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cen_n,
    input logic [11:0] addr,
    input logic [15:0] wdata,
    input logic [1:0]  wen_n,
    input logic [15:0] rdata,
    input logic        ram_ce,
    input logic        ram_we,
    input logic [1:0]  ram_be
);
    // R3 / R4: global write enable agrees with the byte enables
    p_we_matches_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we == (ram_be != 2'b00));

    // R7: deselected cycle leaves read data unchanged
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cen_n |=> $stable(rdata));

    // R8: full write shows the new word
    p_full_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && wen_n == 2'b00) |=> rdata == $past(wdata));

    // R5: low-lane write shows the new low byte
    p_low_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && wen_n == 2'b10) |=> rdata[7:0] == $past(wdata[7:0]));

    // R5: high-lane write shows the new high byte
    p_high_lane_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen_n && wen_n == 2'b01) |=> rdata[15:8] == $past(wdata[15:8]));

    // R2: clock enable follows the select
    p_ce_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ram_ce != cen_n);
endmodule

bind sram_bridge sram_bridge_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cen_n  (cen_n),
    .addr   (addr),
    .wdata  (wdata),
    .wen_n  (wen_n),
    .rdata  (rdata),
    .ram_ce (ram_ce),
    .ram_we (ram_we),
    .ram_be (ram_be)
);

// File: tb/sram_bridge_test.sv
`timescale 1ns/1ps
module sram_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cen_n = 1'b1;
    logic [11:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [1:0]  wen_n = 2'b11;
    logic [15:0] rdata;
    logic        ram_ce, ram_we;
    logic [1:0]  ram_be;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [15:0] model [4096];
    logic [15:0] exp_rd = '0;

    always #2 clk = ~clk;

    sram_bridge uut (
        .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .addr(addr),
        .wdata(wdata), .wen_n(wen_n), .rdata(rdata),
        .ram_ce(ram_ce), .ram_we(ram_we), .ram_be(ram_be)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] nw,
                                          input logic [1:0] s);
        merge[7:0]  = s[0] ? old[7:0]  : nw[7:0];
        merge[15:8] = s[1] ? old[15:8] : nw[15:8];
    endfunction

    // one bus cycle: drive at negedge, check decode, then rdata one edge later
    task automatic cyc(input logic c, input logic [11:0] a, input logic [15:0] d,
                       input logic [1:0] s, input bit full);
        @(negedge clk);
        cen_n = c; addr = a; wdata = d; wen_n = s;
        #0.5;
        if (full) begin
            chk("R2 ram_ce", {15'd0, ram_ce}, {15'd0, ~c});
            chk("R3 ram_we", {15'd0, ram_we}, {15'd0, ~&s});
            chk("R4 ram_be", {14'd0, ram_be}, {14'd0, ~s});
        end
        if (!c) begin
            logic [15:0] nv;
            nv = merge(model[a], d, s);
            exp_rd = nv;
            model[a] = nv;
        end
        @(negedge clk);
        if (full) chk(c ? "R7 hold" : (s == 2'b11 ? "R6 read" : "R8 write view"), rdata, exp_rd);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL R6 watchdog actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R10 reset", rdata, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 after release", rdata, 16'h0000);

        // R1 extremes
        cyc(1'b0, 12'h000, 16'hA1B2, 2'b00, 1);
        cyc(1'b0, 12'hFFF, 16'hC3D4, 2'b00, 1);
        cyc(1'b0, 12'h000, 16'h0000, 2'b11, 1);
        chk("R1 addr 0", rdata, 16'hA1B2);
        cyc(1'b0, 12'hFFF, 16'h0000, 2'b11, 1);
        chk("R1 addr 4095", rdata, 16'hC3D4);

        // R5 partial writes keep the other lane
        cyc(1'b0, 12'h080, 16'h1234, 2'b00, 1);
        cyc(1'b0, 12'h080, 16'hFFAB, 2'b10, 1);
        cyc(1'b0, 12'h080, 16'h0000, 2'b11, 1);
        chk("R5 low lane only", rdata, 16'h12AB);
        cyc(1'b0, 12'h080, 16'hCDFF, 2'b01, 1);
        cyc(1'b0, 12'h080, 16'h0000, 2'b11, 1);
        chk("R5 high lane only", rdata, 16'hCDAB);

        // R7 deselected cycles with write strobes: no store, rdata held
        cyc(1'b1, 12'h080, 16'h5555, 2'b00, 1);
        cyc(1'b1, 12'h000, 16'h6666, 2'b10, 1);
        chk("R7 rdata held", rdata, 16'hCDAB);
        cyc(1'b0, 12'h080, 16'h0000, 2'b11, 1);
        chk("R7 no stray write", rdata, 16'hCDAB);

        // R9 write then immediate read of same address
        cyc(1'b0, 12'h3C5, 16'hBEEF, 2'b00, 1);
        cyc(1'b0, 12'h3C5, 16'h0000, 2'b11, 1);
        chk("R9 read after write", rdata, 16'hBEEF);

        // seed a small pool, then random traffic
        for (int i = 0; i < 16; i++) cyc(1'b0, 12'(i * 257), 16'($urandom), 2'b00, 0);
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] a;
            a = 12'(($urandom % 16) * 257);
            cyc(1'($urandom % 4 == 0), a, 16'($urandom), 2'($urandom), 1);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule